// File: doc/BRIEF.md
# Serial Register Access Port

This block is a four-wire serial slave that gives a controller access to a bank of byte-wide configuration and status registers. The controller lowers an active-low select, supplies a serial clock, sets a read/write level and exchanges bits over one bidirectional data pin. Every transfer is sixteen serial clocks long. The first eight bits carry an address and the last eight carry the data, each most significant bit first. Address bit 0 has no effect, so bits 7:1 pick the register.

The low register indices are writable. Their values sit in the master-clock domain and leave the block as one flat bus to the rest of the chip. A fixed upper range of indices is read-only and shows status inputs supplied by the chip. Indices past the last register read back as zero, and writes to them are dropped.

The serial front end runs on the serial clock, and raising the select resets it asynchronously. A completed write reaches the master-clock domain as a toggle that passes through a two-flop synchronizer. The register update happens on the pulse recovered from that toggle.

Top module: `sreg_port`

## Requirements
- R1: After the synchronous reset, every writable register is zero on `cfg_out` and also reads back as zero.
- R2: A write is an address byte followed by a data byte, both most significant bit first, each sampled on a rising serial clock edge with `rw` low. It stores the data byte in register index addr[7:1], which occupies bits index*8 +: 8 of `cfg_out`.
- R3: Address bit 0 is ignored, so addresses 2k and 2k+1 reach the same register for both reads and writes.
- R4: With `rw` high, the rising edge that samples the eighth address bit drives the register's bit 7 onto `sdio`. The following seven rising edges each drive the next lower bit, so a controller sampling on falling edges receives the byte most significant bit first.
- R5: Indices RO_FIRST to NUM_REGS-1 (80 to 95 by default) read back byte j of `status_in`, where j is the index minus RO_FIRST. Writes to these indices leave `cfg_out` unchanged.
- R6: Indices at or above NUM_REGS (addresses 192 to 255 by default) read back as zero, and writes to them leave `cfg_out` unchanged.
- R7: Raising `cs_n` before the sixteenth bit abandons the transfer without a write. The next transfer starts again at address bit 7.
- R8: The block drives `sdio` only while `cs_n` is low, `rw` is high and the address byte has been fully received. At all other times the pin is high impedance.
- R9: A completed write appears on `cfg_out` within 8 master-clock cycles of the sixteenth rising serial clock edge. `cfg_out` never changes except through such a write or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset; it also clears the write toggle asynchronously |
| sck | input | 1 | Serial clock from the controller, asynchronous to clk |
| cs_n | input | 1 | Active-low select; a high level resets the serial state |
| rw | input | 1 | 1 = read, 0 = write |
| sdio | inout | 1 | Bidirectional serial address/data |
| status_in | input | (NUM_REGS-RO_FIRST)*DATA_W | Read-only register values, byte j for index RO_FIRST+j |
| cfg_out | output | RO_FIRST*DATA_W | Writable register contents in the clk domain |

## Verification
The bench builds the default configuration: 96 registers, 80 writable and 16 read-only, with 8-bit addresses. With those values a sweep over all 128 register indices fits within a short run. That sweep writes every index, using alternating address-LSB values, and reads every index back. It therefore reaches the writable, read-only and out-of-range regions and both cases of the ignored bit. Truncated transfers of 12 and 15 bits test the abandon path. The bench also samples `cfg_out` eight master cycles after the last serial edge, which bounds the synchronizer latency.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_BITS = 8;
  localparam int DATA_BITS = 8;
  localparam int REG_COUNT = 96;
  localparam int RO_START  = 80;

  // index width for an array of n entries, never below one bit
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sreg_serial.sv
module sreg_serial #(
  parameter int AW = sreg_pkg::ADDR_BITS,
  parameter int DW = sreg_pkg::DATA_BITS
) (
  input  logic          sck,
  input  logic          cs_n,
  input  logic          rst,
  input  logic          rw,
  input  logic          sd_in,
  input  logic [DW-1:0] rd_data,
  output logic [AW-2:0] rd_idx,
  output logic          sd_out,
  output logic          sd_oe,
  output logic [AW-2:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          wr_tgl
);
  localparam int TOT = AW + DW;
  localparam int CW  = $clog2(TOT + 1);
  localparam logic [CW-1:0] C_ADDR_LAST  = CW'(AW - 1);
  localparam logic [CW-1:0] C_DATA_FIRST = CW'(AW);
  localparam logic [CW-1:0] C_DATA_LAST  = CW'(TOT - 1);
  localparam logic [CW-1:0] C_DONE       = CW'(TOT);

  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_sr;
  logic [DW-2:0] dat_sr;
  logic [DW-1:0] rd_sr;
  logic          rd_phase;

  // serial state: cleared asynchronously whenever the select is released
  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      cnt      <= '0;
      addr_sr  <= '0;
      dat_sr   <= '0;
      rd_sr    <= '0;
      rd_phase <= 1'b0;
    end else begin
      if (cnt != C_DONE)
        cnt <= cnt + 1'b1;
      if (cnt <= C_ADDR_LAST)
        addr_sr <= {addr_sr[AW-2:0], sd_in};
      if (cnt >= C_DATA_FIRST && cnt < C_DATA_LAST)
        dat_sr <= {dat_sr[DW-3:0], sd_in};
      if (cnt == C_ADDR_LAST) begin
        rd_phase <= rw;
        rd_sr    <= rd_data;
      end else if (rd_phase && cnt < C_DATA_LAST) begin
        rd_sr <= {rd_sr[DW-2:0], 1'b0};
      end
    end
  end

  // completed write: hold address/data and flip the crossing toggle
  always_ff @(posedge sck or posedge rst) begin
    if (rst) begin
      wr_idx  <= '0;
      wr_data <= '0;
      wr_tgl  <= 1'b0;
    end else if (!cs_n && cnt == C_DATA_LAST && !rw) begin
      wr_idx  <= addr_sr[AW-1:1];
      wr_data <= {dat_sr, sd_in};
      wr_tgl  <= ~wr_tgl;
    end
  end

  assign rd_idx = addr_sr[AW-2:0];
  assign sd_out = rd_sr[DW-1];
  assign sd_oe  = rd_phase & rw & ~cs_n;

  assert_cnt_bound_R2: assert property (@(posedge sck) disable iff (cs_n)
    cnt <= C_DONE);
  assert_quiet_addr_R8: assert property (@(posedge sck) disable iff (cs_n)
    (cnt < C_ADDR_LAST) |-> !sd_oe);
  assert_quiet_write_R8: assert property (@(posedge sck) disable iff (cs_n)
    !rw |-> !sd_oe);
  assert_drive_read_R4: assert property (@(posedge sck) disable iff (cs_n)
    (cnt == C_ADDR_LAST && rw) |=> (sd_oe || !rw));
endmodule

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], tgl_in};
  end

  assign pulse = sh[STAGES] ^ sh[STAGES-1];

  assert_pulse_once_R9: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/sreg_file.sv
module sreg_file #(
  parameter int IW       = sreg_pkg::ADDR_BITS - 1,
  parameter int DW       = sreg_pkg::DATA_BITS,
  parameter int NREG     = sreg_pkg::REG_COUNT,
  parameter int RO_FIRST = sreg_pkg::RO_START
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          commit,
  input  logic [IW-1:0]                 wr_idx,
  input  logic [DW-1:0]                 wr_data,
  input  logic [IW-1:0]                 rd_idx,
  input  logic [(NREG-RO_FIRST)*DW-1:0] status_in,
  output logic [DW-1:0]                 rd_data,
  output logic [RO_FIRST*DW-1:0]        cfg_out
);
  localparam int RW_COUNT = RO_FIRST;
  localparam int RO_COUNT = NREG - RO_FIRST;
  localparam int RW_IW    = sreg_pkg::idx_bits(RW_COUNT);
  localparam int RO_IW    = sreg_pkg::idx_bits(RO_COUNT);

  logic [DW-1:0] regs [RW_COUNT];
  logic [DW-1:0] st   [RO_COUNT];
  logic [IW-1:0] ro_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RW_COUNT; i++) regs[i] <= '0;
    end else if (commit && int'(wr_idx) < RW_COUNT) begin
      regs[wr_idx[RW_IW-1:0]] <= wr_data;
    end
  end

  for (genvar g = 0; g < RW_COUNT; g++) begin : g_cfg
    assign cfg_out[g*DW +: DW] = regs[g];
  end
  for (genvar g = 0; g < RO_COUNT; g++) begin : g_st
    assign st[g] = status_in[g*DW +: DW];
  end

  assign ro_off = rd_idx - IW'(RO_FIRST);

  always_comb begin
    if (int'(rd_idx) < RW_COUNT)  rd_data = regs[rd_idx[RW_IW-1:0]];
    else if (int'(rd_idx) < NREG) rd_data = st[ro_off[RO_IW-1:0]];
    else                          rd_data = '0;
  end

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(cfg_out));
  assert_ro_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && int'(wr_idx) >= RW_COUNT) |=> $stable(cfg_out));
endmodule

// File: rtl/sreg_port.sv
module sreg_port #(
  parameter int ADDR_W   = sreg_pkg::ADDR_BITS,
  parameter int DATA_W   = sreg_pkg::DATA_BITS,
  parameter int NUM_REGS = sreg_pkg::REG_COUNT,
  parameter int RO_FIRST = sreg_pkg::RO_START
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              sck,
  input  logic                              cs_n,
  input  logic                              rw,
  inout  wire                               sdio,
  input  logic [(NUM_REGS-RO_FIRST)*DATA_W-1:0] status_in,
  output logic [RO_FIRST*DATA_W-1:0]        cfg_out
);
  localparam int IW = ADDR_W - 1;

  logic [IW-1:0]     rd_idx, wr_idx;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              sd_out, sd_oe, wr_tgl, commit;

  assign sdio = sd_oe ? sd_out : 1'bz;

  sreg_serial #(.AW(ADDR_W), .DW(DATA_W)) u_serial (
    .sck(sck), .cs_n(cs_n), .rst(rst), .rw(rw), .sd_in(sdio),
    .rd_data(rd_data), .rd_idx(rd_idx), .sd_out(sd_out), .sd_oe(sd_oe),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_tgl(wr_tgl)
  );

  sreg_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .tgl_in(wr_tgl), .pulse(commit)
  );

  sreg_file #(.IW(IW), .DW(DATA_W), .NREG(NUM_REGS), .RO_FIRST(RO_FIRST)) u_file (
    .clk(clk), .rst(rst), .commit(commit), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .status_in(status_in), .rd_data(rd_data), .cfg_out(cfg_out)
  );
endmodule

// File: tb/sreg_port_bench.sv
`timescale 1ns/1ps
module sreg_port_bench;
  localparam int NREG = 96, RWN = 80, RON = 16;
  localparam time HALF = 32ns;

  logic clk = 0, rst = 1, sck = 0, cs_n = 1, rw = 0;
  logic drv_en = 0, drv_bit = 0;
  tri   sdio;
  logic [RON*8-1:0] status_in;
  logic [RWN*8-1:0] cfg_out, model, cfg_end;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  assign sdio = drv_en ? drv_bit : 1'bz;
  always #4 clk = ~clk;

  sreg_port u_sreg_port (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .rw(rw), .sdio(sdio),
    .status_in(status_in), .cfg_out(cfg_out)
  );

  function automatic logic [7:0] fpat(input int i);  return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] spat(input int j);  return 8'(((j * 11) ^ 8'hA5) & 255); endfunction
  function automatic logic [7:0] spat2(input int j); return 8'((j * 7 + 3) & 255); endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input logic [RWN*8-1:0] act, input logic [RWN*8-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit rd, input logic [7:0] addr, input logic [7:0] wdat,
                      input int nbits, output logic [7:0] rdat);
    rdat = '0;
    @(negedge clk); #1;
    cs_n = 0; rw = rd; #HALF;
    for (int i = 0; i < nbits; i++) begin
      if (i < 7 || (i == 7 && !rd)) begin drv_en = 1; drv_bit = addr[7-i]; end
      else if (i >= 8 && !rd)       begin drv_en = 1; drv_bit = wdat[15-i]; end
      else                                 drv_en = 0;
      #HALF sck = 1;
      #1;
      if (!rd && i >= 8 && i == 12)
        chk8("R8 pin follows controller during write", {7'd0, sdio}, {7'd0, drv_bit});
      #(HALF - 1ns) sck = 0;
      if (rd && i >= 7 && i <= 14) begin #1; rdat[14-i] = sdio; end
    end
    drv_en = 0;
    #HALF;
    cfg_end = cfg_out;
    cs_n = 1; rw = 0;
    repeat (12) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] a;
    string tag;
    for (int j = 0; j < RON; j++) status_in[j*8 +: 8] = spat(j);
    model = '0;
    repeat (5) @(posedge clk);
    rst = 0;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    chkv("R1 cfg_out after reset", cfg_out, '0);
    xfer(1, 8'd10, 8'd0, 16, r);
    chk8("R1 readback after reset", r, 8'h00);

    // R2/R5/R6 write sweep over every index, LSB alternating (R3)
    for (int idx = 0; idx < 128; idx++) begin
      a = 8'(idx * 2 + (idx & 1));
      xfer(0, a, fpat(idx), 16, r);
      if (idx < RWN) model[idx*8 +: 8] = fpat(idx);
      tag = (idx < RWN) ? "R2 write sweep" : (idx < NREG) ? "R5 read-only write ignored"
                                                         : "R6 out-of-range write ignored";
      chkv(tag, cfg_out, model);
    end

    // R4/R5/R6 read sweep, LSB pattern differs from the write sweep (R3)
    for (int idx = 0; idx < 128; idx++) begin
      a = 8'(idx * 2 + ((idx >> 1) & 1));
      xfer(1, a, 8'd0, 16, r);
      if (idx < RWN)       chk8("R4 read sweep", r, fpat(idx));
      else if (idx < NREG) chk8("R5 status readback", r, spat(idx - RWN));
      else                 chk8("R6 out-of-range reads zero", r, 8'h00);
    end

    // R3 even and odd address hit one register
    xfer(0, 8'h14, 8'h5A, 16, r); model[10*8 +: 8] = 8'h5A;
    xfer(0, 8'h15, 8'hC3, 16, r); model[10*8 +: 8] = 8'hC3;
    chkv("R3 odd address overwrites even", cfg_out, model);
    xfer(1, 8'h14, 8'd0, 16, r);
    chk8("R3 read via even address", r, 8'hC3);

    // R9 latency bound: visible 8 clk after the last serial edge
    xfer(0, 8'd24, 8'h3C, 16, r); model[12*8 +: 8] = 8'h3C;
    chkv("R9 write visible within 8 cycles", cfg_end, model);

    // R7 abandoned transfers
    xfer(0, 8'd6, 8'h99, 12, r);
    chkv("R7 12-bit abort no write", cfg_out, model);
    xfer(0, 8'd6, 8'h99, 15, r);
    chkv("R7 15-bit abort no write", cfg_out, model);
    xfer(1, 8'd40, 8'd0, 10, r);
    xfer(1, 8'd6, 8'd0, 16, r);
    chk8("R7 fresh transfer after abort", r, fpat(3));
    xfer(0, 8'd8, 8'hE1, 16, r); model[4*8 +: 8] = 8'hE1;
    chkv("R7 full write after aborts", cfg_out, model);

    // R5 live status value
    for (int j = 0; j < RON; j++) status_in[j*8 +: 8] = spat2(j);
    xfer(1, 8'd183, 8'd0, 16, r);
    chk8("R5 status follows input", r, spat2(11));
    xfer(0, 8'd183, 8'h00, 16, r);
    xfer(1, 8'd182, 8'd0, 16, r);
    chk8("R5 status unchanged by write", r, spat2(11));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule